// File: doc/BRIEF.md
# Analog Channel Scan Sequencer

This block keeps a queue of scan entries and walks through it, one conversion at a time. Each entry selects an input channel, a gain code, single-ended or differential mode, and the two expansion fields. Before the walk starts, the host loads the queue one byte at a time over an 8-bit path. For each entry the sequencer issues a one-cycle conversion-start strobe. During that conversion it holds the entry's fields on its outputs. It moves to the next entry when the converter returns its done pulse.

An entry that has its start flag set waits for a pacer tick. An entry without the flag follows the previous conversion at the selected burst spacing. This lets one queue run in two ways. If every entry is flagged, the queue takes one conversion per tick. If only the first entry is flagged, the queue takes a whole burst per tick. After the last entry the sequencer pulses end-of-scan. It then either wraps to entry 0 (continuous mode) or goes idle (one-shot mode).

The gain code maps to the ranges ±10 V, ±5 V, ±2.5 V and ±1.25 V for codes 0 to 3. The block only passes the code through to its outputs.

Top module: `chan_scan_seq`

## Requirements
- R1: An entry is written as two byte loads (`ld_en_i`): the low byte first, then the high byte. The entry is stored only after the high byte. Entries run in the order they were written. The 16-bit entry is laid out as: bit 14 differential, bits 13:12 gain, bits 11:8 channel, bit 7 start flag, bits 5:4 expansion gain, bits 3:0 expansion channel. These fields appear on `diff_o`, `gain_o`, `chan_o`, `xgain_o` and `xchan_o` from the cycle of each entry's `conv_start_o`.
- R2: `qrst_i` empties the queue and resets the write pointer and the byte phase. It also returns the sequencer to idle. An `arm_i` with an empty queue has no effect.
- R3: An entry with its start flag set does not start until a pacer tick. `conv_start_o` rises in the cycle after `tick_i` is sampled high while that entry is waiting.
- R4: An entry without the start flag starts exactly P cycles after the previous conversion's start, provided the previous done pulse has arrived by then.
- R5: `rate_i` sets P: 0 gives BASE_CYC, 1 gives 2×BASE_CYC, and 2 or 3 gives 4×BASE_CYC.
- R6: In continuous mode (`cont_i`=1 at arm), the sequencer returns to entry 0 after the last entry's done and stays busy.
- R7: In one-shot mode the sequencer goes idle (`busy_o`=0) after the last entry's done.
- R8: `eos_o` is a one-cycle pulse in the cycle after the done pulse of the last entry.
- R9: `conv_start_o` is a one-cycle pulse. The field outputs change only together with it.
- R10: Byte loads are ignored while the sequencer is busy. Entries beyond DEPTH are dropped.
- R11: `stop_i` returns the sequencer to idle. No further conversion starts until the next arm.
- R12: After reset the sequencer is idle, the queue is empty, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_en_i | input | 1 | Byte load strobe for the queue |
| ld_byte_i | input | 8 | Byte of an entry, low byte first |
| qrst_i | input | 1 | Empty the queue and stop |
| arm_i | input | 1 | Start walking the queue from entry 0 |
| stop_i | input | 1 | Abort the scan and go idle |
| cont_i | input | 1 | 1: wrap after the last entry, 0: one pass |
| rate_i | input | 2 | Burst spacing select |
| tick_i | input | 1 | Pacer tick |
| conv_done_i | input | 1 | Conversion complete pulse |
| conv_start_o | output | 1 | Conversion start strobe |
| diff_o | output | 1 | Differential mode of the current entry |
| gain_o | output | 2 | Gain code of the current entry |
| chan_o | output | 4 | Channel of the current entry |
| xgain_o | output | 2 | Expansion gain of the current entry |
| xchan_o | output | 4 | Expansion channel of the current entry |
| busy_o | output | 1 | Sequencer is armed or converting |
| eos_o | output | 1 | End-of-scan pulse |

## Verification
The properties assume the converter returns exactly one done pulse per start strobe, and only after that strobe. They also assume that `tick_i`, `arm_i`, `stop_i` and `qrst_i` are single-cycle pulses, and that `rate_i` stays constant while a burst runs. The bench keeps within these assumptions in three ways. A responder answers each start with a done pulse one cycle later. Every control pulse is driven for exactly one cycle. The rate changes only while the sequencer is idle.

// File: rtl/chan_scan_pkg.sv
package chan_scan_pkg;
  typedef struct packed {
    logic       rsv_hi;
    logic       diff;
    logic [1:0] gain;
    logic [3:0] chan;
    logic       start;
    logic       rsv_lo;
    logic [1:0] xgain;
    logic [3:0] xchan;
  } scan_entry_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CONV} seq_state_t;
endpackage

// File: rtl/chan_scan_store.sv
module chan_scan_store
  import chan_scan_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_en_i,
  input  logic [7:0]    ld_byte_i,
  input  logic          qrst_i,
  input  logic          lock_i,
  input  logic [AW-1:0] rd_idx_i,
  output scan_entry_t   rd_entry_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [7:0]    lo_q;
  logic          hi_phase_q;
  logic [CW-1:0] cnt_q;
  logic [15:0]   mem_q [DEPTH];
  logic          take, commit;

  assign take   = ld_en_i && !lock_i && !qrst_i;
  assign commit = take && hi_phase_q && (cnt_q != DEPTH_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q       <= '0;
      hi_phase_q <= 1'b0;
      cnt_q      <= '0;
    end else if (qrst_i) begin
      hi_phase_q <= 1'b0;
      cnt_q      <= '0;
    end else if (take) begin
      hi_phase_q <= !hi_phase_q;
      if (!hi_phase_q) lo_q <= ld_byte_i;
      if (commit) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (commit) mem_q[cnt_q[AW-1:0]] <= {ld_byte_i, lo_q};
  end

  assign rd_entry_o = scan_entry_t'(mem_q[rd_idx_i]);
  assign count_o    = cnt_q;
endmodule

// File: rtl/chan_scan_gap.sv
module chan_scan_gap #(
  parameter int BASE_CYC = 1250,
  localparam int GW = $clog2(4 * BASE_CYC + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] rate_i,
  output logic       expired_o
);
  logic [GW-1:0] gap_q;
  logic [GW-1:0] period;

  always_comb begin
    case (rate_i)
      2'd0:    period = GW'(BASE_CYC);
      2'd1:    period = GW'(2 * BASE_CYC);
      default: period = GW'(4 * BASE_CYC);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              gap_q <= '0;
    else if (load_i)          gap_q <= period - 1'b1;
    else if (gap_q != '0)     gap_q <= gap_q - 1'b1;
  end

  assign expired_o = (gap_q == '0);
endmodule

// File: rtl/chan_scan_fsm.sv
module chan_scan_fsm
  import chan_scan_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          stop_i,
  input  logic          qrst_i,
  input  logic          cont_i,
  input  logic          tick_i,
  input  logic          done_i,
  input  logic          gap_ok_i,
  input  scan_entry_t   entry_i,
  input  logic [CW-1:0] count_i,
  output logic [AW-1:0] idx_o,
  output logic          launch_o,
  output logic          start_o,
  output logic          eos_o,
  output logic          busy_o,
  output scan_entry_t   fields_o
);
  seq_state_t    state_q;
  logic [AW-1:0] idx_q;
  logic          cont_q, start_q, eos_q, last, launch, abort;
  scan_entry_t   fields_q;

  assign abort  = stop_i || qrst_i;
  assign last   = (CW'(idx_q) + 1'b1) == count_i;
  // flagged entries wait for the pacer, the rest for the burst gap
  assign launch = (state_q == ST_WAIT) && (entry_i.start ? tick_i : gap_ok_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      cont_q   <= 1'b0;
      start_q  <= 1'b0;
      eos_q    <= 1'b0;
      fields_q <= '0;
    end else begin
      start_q <= 1'b0;
      eos_q   <= 1'b0;
      if (abort) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: if (arm_i && count_i != '0) begin
            idx_q   <= '0;
            cont_q  <= cont_i;
            state_q <= ST_WAIT;
          end
          ST_WAIT: if (launch) begin
            start_q  <= 1'b1;
            fields_q <= entry_i;
            state_q  <= ST_CONV;
          end
          ST_CONV: if (done_i) begin
            if (last) begin
              eos_q <= 1'b1;
              idx_q <= '0;
              state_q <= cont_q ? ST_WAIT : ST_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_WAIT;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign idx_o    = idx_q;
  assign launch_o = launch && !abort;
  assign start_o  = start_q;
  assign eos_o    = eos_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign fields_o = fields_q;
endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq
  import chan_scan_pkg::*;
#(
  parameter int DEPTH    = 2048,
  parameter int BASE_CYC = 1250
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_en_i,
  input  logic [7:0] ld_byte_i,
  input  logic       qrst_i,
  input  logic       arm_i,
  input  logic       stop_i,
  input  logic       cont_i,
  input  logic [1:0] rate_i,
  input  logic       tick_i,
  input  logic       conv_done_i,
  output logic       conv_start_o,
  output logic       diff_o,
  output logic [1:0] gain_o,
  output logic [3:0] chan_o,
  output logic [1:0] xgain_o,
  output logic [3:0] xchan_o,
  output logic       busy_o,
  output logic       eos_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  scan_entry_t   entry, fields;
  logic [AW-1:0] idx;
  logic [CW-1:0] count;
  logic          gap_ok, launch;

  chan_scan_store #(.DEPTH(DEPTH)) store_i (
    .clk_i, .rst_ni, .ld_en_i, .ld_byte_i, .qrst_i,
    .lock_i(busy_o), .rd_idx_i(idx), .rd_entry_o(entry), .count_o(count)
  );

  chan_scan_gap #(.BASE_CYC(BASE_CYC)) gap_i (
    .clk_i, .rst_ni, .load_i(launch), .rate_i, .expired_o(gap_ok)
  );

  chan_scan_fsm #(.DEPTH(DEPTH)) fsm_i (
    .clk_i, .rst_ni, .arm_i, .stop_i, .qrst_i, .cont_i, .tick_i,
    .done_i(conv_done_i), .gap_ok_i(gap_ok), .entry_i(entry), .count_i(count),
    .idx_o(idx), .launch_o(launch), .start_o(conv_start_o), .eos_o,
    .busy_o, .fields_o(fields)
  );

  assign diff_o  = fields.diff;
  assign gain_o  = fields.gain;
  assign chan_o  = fields.chan;
  assign xgain_o = fields.xgain;
  assign xchan_o = fields.xchan;
endmodule

// File: rtl/chan_scan_seq_chk.sv
module chan_scan_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       qrst_i,
  input logic       stop_i,
  input logic       conv_done_i,
  input logic       conv_start_o,
  input logic       diff_o,
  input logic [1:0] gain_o,
  input logic [3:0] chan_o,
  input logic [1:0] xgain_o,
  input logic [3:0] xchan_o,
  input logic       busy_o,
  input logic       eos_o
);
  logic [12:0] flds;
  assign flds = {diff_o, gain_o, chan_o, xgain_o, xchan_o};

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) conv_start_o |=> !conv_start_o); // R9
  AST_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !conv_start_o |-> $stable(flds)); // R9
  AST_EOS_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni) eos_o |-> $past(conv_done_i)); // R8
  AST_EOS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) eos_o |=> !eos_o); // R8
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) $past(stop_i) |-> (!busy_o && !conv_start_o)); // R11
  AST_QRST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) $past(qrst_i) |-> !busy_o); // R2
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) conv_start_o |-> busy_o); // R3
endmodule

bind chan_scan_seq chan_scan_seq_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .qrst_i(qrst_i), .stop_i(stop_i),
  .conv_done_i(conv_done_i), .conv_start_o(conv_start_o), .diff_o(diff_o),
  .gain_o(gain_o), .chan_o(chan_o), .xgain_o(xgain_o), .xchan_o(xchan_o),
  .busy_o(busy_o), .eos_o(eos_o)
);

// File: tb/chan_scan_seq_tb_top.sv
`timescale 1ns/1ps
module chan_scan_seq_tb_top;
  localparam int DEPTH = 8;
  localparam int BASE  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0, qrst = 1'b0, arm = 1'b0, stop = 1'b0, cont = 1'b0, tick = 1'b0;
  logic [7:0] ld_byte = '0;
  logic [1:0] rate = '0;
  logic conv_done;
  logic conv_start, diff, busy, eos;
  logic [1:0] gain, xgain;
  logic [3:0] chan, xchan;

  int checks = 0, errors = 0, cyc = 0;
  int n_st = 0, n_eos = 0, eos_cyc = 0;
  int st_cyc [64];
  logic [12:0] st_fld [64];
  bit resp_en = 1'b0, finished = 1'b0;

  always #4 clk = ~clk;

  chan_scan_seq #(.DEPTH(DEPTH), .BASE_CYC(BASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ld_en_i(ld_en), .ld_byte_i(ld_byte),
    .qrst_i(qrst), .arm_i(arm), .stop_i(stop), .cont_i(cont), .rate_i(rate),
    .tick_i(tick), .conv_done_i(conv_done), .conv_start_o(conv_start),
    .diff_o(diff), .gain_o(gain), .chan_o(chan), .xgain_o(xgain),
    .xchan_o(xchan), .busy_o(busy), .eos_o(eos)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // converter model: done one cycle after each start
  always @(negedge clk) conv_done <= resp_en && conv_start;

  always @(negedge clk) begin
    if (conv_start && n_st < 64) begin
      st_cyc[n_st] = cyc;
      st_fld[n_st] = {diff, gain, chan, xgain, xchan};
      n_st = n_st + 1;
    end
    if (eos) begin
      n_eos = n_eos + 1;
      eos_cyc = cyc;
    end
  end

  function automatic logic [12:0] fld(input logic [15:0] w);
    return {w[14], w[13:12], w[11:8], w[5:4], w[3:0]};
  endfunction

  function automatic int period(input int r);
    return (r == 0) ? BASE : (r == 1) ? 2 * BASE : 4 * BASE;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] w);
    @(negedge clk); ld_en = 1'b1; ld_byte = w[7:0];
    @(negedge clk); ld_byte = w[15:8];
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic pulse_qrst();
    @(negedge clk); qrst = 1'b1;
    @(negedge clk); qrst = 1'b0;
  endtask

  task automatic do_arm(input bit c, input logic [1:0] r);
    @(negedge clk); cont = c; rate = r; arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic do_tick(output int t);
    @(negedge clk); tick = 1'b1; t = cyc;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic clear_log();
    n_st = 0; n_eos = 0;
  endtask

  task automatic test_reset();
    check(busy == 1'b0, "R12 busy", busy, 0);
    check(conv_start == 1'b0 && eos == 1'b0, "R12 strobes", conv_start | eos, 0);
    check({diff, gain, chan, xgain, xchan} == '0, "R12 fields", {diff, gain, chan, xgain, xchan}, 0);
  endtask

  task automatic test_per_tick();
    logic [15:0] w [3];
    int t;
    w[0] = 16'h6195; w[1] = 16'h13AA; w[2] = 16'h7CBF;
    pulse_qrst();
    for (int i = 0; i < 3; i++) load(w[i]);
    clear_log();
    do_arm(1'b0, 2'd0);
    cycles(6);
    check(n_st == 0, "R3 no start without tick", n_st, 0);
    for (int k = 0; k < 3; k++) begin
      do_tick(t);
      cycles(4);
      check(n_st == k + 1, "R3 one conversion per tick", n_st, k + 1);
      check(st_cyc[k] == t + 1, "R3 start cycle after tick", st_cyc[k], t + 1);
      check(st_fld[k] == fld(w[k]), "R1 entry fields", st_fld[k], fld(w[k]));
    end
    cycles(3);
    check(n_eos == 1, "R8 one eos per pass", n_eos, 1);
    check(eos_cyc == st_cyc[2] + 1, "R8 eos timing", eos_cyc, st_cyc[2] + 1);
    check(busy == 1'b0, "R7 idle after one-shot pass", busy, 0);
  endtask

  task automatic test_burst();
    int t;
    pulse_qrst();
    load(16'h0480); load(16'h1500); load(16'h0600);
    for (int r = 0; r < 4; r++) begin
      clear_log();
      do_arm(1'b0, 2'(r));
      do_tick(t);
      cycles(40);
      check(n_st == 3, "R4 burst count", n_st, 3);
      check(st_cyc[1] - st_cyc[0] == period(r), "R5 spacing 0-1", st_cyc[1] - st_cyc[0], period(r));
      check(st_cyc[2] - st_cyc[1] == period(r), "R4 spacing 1-2", st_cyc[2] - st_cyc[1], period(r));
      check(st_fld[2] == fld(16'h0600), "R1 burst order", st_fld[2], fld(16'h0600));
      check(n_eos == 1 && !busy, "R7 burst pass end", n_eos, 1);
    end
  endtask

  task automatic test_continuous();
    int t;
    clear_log();
    do_arm(1'b1, 2'd0);
    do_tick(t);
    cycles(30);
    check(n_st == 3 && n_eos == 1, "R6 first pass", n_st, 3);
    check(busy == 1'b1, "R6 still busy after wrap", busy, 1);
    load(16'h0700);
    do_tick(t);
    cycles(30);
    check(n_st == 6, "R6 second pass", n_st, 6);
    check(st_fld[3] == fld(16'h0480), "R6 wrapped to entry 0", st_fld[3], fld(16'h0480));
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    cycles(2);
    check(busy == 1'b0, "R11 idle after stop", busy, 0);
    do_tick(t);
    cycles(10);
    check(n_st == 6, "R11 no start after stop", n_st, 6);
    clear_log();
    do_arm(1'b0, 2'd0);
    do_tick(t);
    cycles(40);
    check(n_st == 3, "R10 load while busy ignored", n_st, 3);
  endtask

  task automatic test_full();
    pulse_qrst();
    for (int i = 0; i < 10; i++) load(16'(i << 8));
    clear_log();
    cycles(20);
    do_arm(1'b0, 2'd0);
    cycles(60);
    check(n_st == DEPTH, "R10 entries beyond depth dropped", n_st, DEPTH);
    check(st_fld[DEPTH-1] == fld(16'h0700), "R10 last stored entry", st_fld[DEPTH-1], fld(16'h0700));
    check(st_cyc[5] - st_cyc[4] == BASE, "R4 unflagged run spacing", st_cyc[5] - st_cyc[4], BASE);
  endtask

  task automatic test_qrst();
    int t;
    load(16'h0123);
    pulse_qrst();
    clear_log();
    do_arm(1'b0, 2'd0);
    cycles(5);
    check(busy == 1'b0 && n_st == 0, "R2 arm on empty queue", n_st, 0);
    @(negedge clk); ld_en = 1'b1; ld_byte = 8'hFF;
    @(negedge clk); ld_en = 1'b0;
    pulse_qrst();
    load(16'h0380);
    do_arm(1'b0, 2'd0);
    do_tick(t);
    cycles(6);
    check(n_st == 1, "R2 single entry after reset", n_st, 1);
    check(st_fld[0] == fld(16'h0380), "R2 byte phase cleared", st_fld[0], fld(16'h0380));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    resp_en = 1'b1;
    @(negedge clk);
    test_reset();
    test_per_tick();
    test_burst();
    test_continuous();
    test_full();
    test_qrst();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule